// File: doc/BRIEF.md
# Bit-Field Extract Unit

This execution-stage unit takes one 32-bit source operand and copies a contiguous run of its bits into the low end of a 32-bit result. The bits above the copied field are filled with zeros in the zero-extending mode, or with copies of the field's leftmost bit in the sign-extending mode. The field is described by a 5-bit position and a length. Bits are numbered big-endian: bit 0 is the most significant bit of the word and bit 31 the least. The position names the field's rightmost (least significant) bit, and the field extends leftward from there for the given number of bits.

Next to the data, the unit carries an issue strobe and a destination register index. It raises a write enable toward the register file unless the destination is register zero, whose writes are always dropped. If a field would run past bit 0, it is cut off at bit 0 and an illegal-field flag is raised. A parameter selects whether the outputs are registered (one cycle of latency, the default) or purely combinational.

Top module: `bfx_unit`

## Requirements
- R1: With big-endian numbering (bit 0 = MSB, bit 31 = LSB), the field covers source bits pos-len+1 through pos. Bit pos appears at result bit 0 (the LSB), and the field's bits keep their order above it.
- R2: When `sgnExt` is 0, every result bit above the field is 0.
- R3: When `sgnExt` is 1, every result bit above the field equals the field's leftmost bit, which is source bit pos-len+1 in big-endian numbering.
- R4: In the sign-extending mode with length 1, the result is 0x00000000 or 0xFFFFFFFF, matching the selected bit.
- R5: Position 31 with length 16 returns the low 16 bits of the source. These are zero-extended when `sgnExt` is 0 and sign-extended when it is 1.
- R6: Position 31 with length 32 returns the source unchanged in both modes.
- R7: When len > pos+1, the field is cut off at big-endian bit 0, so its effective length is pos+1, and `illegalField` is 1. Length 0 gives a zero result with `illegalField` at 1. Otherwise `illegalField` is 0.
- R8: `wrEn` is 1 only when `issue` is 1 and `destIdx` is not 0. The result is still computed when `destIdx` is 0.
- R9: With the default `OUT_REG`=1, all outputs show the inputs sampled at the previous rising clock edge. While `rstN` is low, `result`, `wrEn` and `illegalField` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| issue | input | 1 | Operation valid this cycle |
| srcVal | input | 32 | Source operand |
| fieldPos | input | 5 | Big-endian index of the field's rightmost bit |
| fieldLen | input | 6 | Field length, legal range 1 to 32 |
| sgnExt | input | 1 | 1 = sign-extend, 0 = zero-extend |
| destIdx | input | 5 | Destination register index |
| result | output | 32 | Right-justified, extended field |
| wrEn | output | 1 | Register-file write enable |
| illegalField | output | 1 | Field ran past bit 0, or length was 0 |

## Verification
The bench targets the places where bit numbering is easy to flip. These are position 31 (the LSB end), position 0 with length 1 (the MSB alone), and fields that straddle a byte boundary. A design that counted bits little-endian would return a mirror-image field, and the halfword and full-word cases would fail at once. The bench also drives lengths longer than pos+1 and length 0. Without clamping, such lengths would pull in bits from the wrong end or take the sign from a bit outside the field. The destination-zero cases with `issue` high show whether a design lets a write to register zero through.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int DATA_W = 32;
  localparam int POS_W  = $clog2(DATA_W);
  localparam int LEN_W  = POS_W + 1;
  localparam int REG_W  = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic             signFill;
    logic [LEN_W-1:0] effLen;
    logic             illegal;
    logic             wrEn;
  } bfxStrobes_t;
endpackage

// File: rtl/bfx_ctrl.sv
module bfx_ctrl
  import bfx_pkg::*;
(
  input  logic             issue,
  input  logic [POS_W-1:0] fieldPos,
  input  logic [LEN_W-1:0] fieldLen,
  input  logic             sgnExt,
  input  logic [REG_W-1:0] destIdx,
  output bfxStrobes_t      strb
);
  logic [LEN_W-1:0] avail;
  logic             overrun;

  always_comb begin
    // bits available from the position up to the MSB end
    avail           = LEN_W'(fieldPos) + LEN_W'(1);
    overrun         = fieldLen > avail;
    strb.effLen     = overrun ? avail : fieldLen;
    strb.illegal    = overrun || (fieldLen == '0);
    strb.signFill   = sgnExt && (strb.effLen != '0);
    strb.wrEn       = issue && (destIdx != '0);
  end
endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath
  import bfx_pkg::*;
(
  input  logic [DATA_W-1:0] srcVal,
  input  logic [POS_W-1:0]  fieldPos,
  input  bfxStrobes_t       strb,
  output logic [DATA_W-1:0] fieldOut
);
  logic [POS_W-1:0]  shAmt;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] keepMask;
  logic [LEN_W-1:0]  topIdx;
  logic              signBit;

  // big-endian position p sits at little-endian index DATA_W-1-p
  assign shAmt   = POS_W'(DATA_W - 1) - fieldPos;
  assign shifted = srcVal >> shAmt;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign keepMask[i] = LEN_W'(i) < strb.effLen;
  end

  assign topIdx  = strb.effLen - LEN_W'(1);
  assign signBit = strb.signFill & shifted[topIdx[POS_W-1:0]];
  assign fieldOut = (shifted & keepMask) | (~keepMask & {DATA_W{signBit}});
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [POS_W-1:0]  fieldPos,
  input  logic [LEN_W-1:0]  fieldLen,
  input  logic              sgnExt,
  input  logic [REG_W-1:0]  destIdx,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              illegalField
);
  bfxStrobes_t       strb;
  logic [DATA_W-1:0] fieldOut;

  bfx_ctrl u_ctrl (
    .issue(issue), .fieldPos(fieldPos), .fieldLen(fieldLen),
    .sgnExt(sgnExt), .destIdx(destIdx), .strb(strb)
  );

  bfx_datapath u_dp (
    .srcVal(srcVal), .fieldPos(fieldPos), .strb(strb), .fieldOut(fieldOut)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        result       <= '0;
        wrEn         <= 1'b0;
        illegalField <= 1'b0;
      end else begin
        result       <= fieldOut;
        wrEn         <= strb.wrEn;
        illegalField <= strb.illegal;
      end
    end
  end else begin : g_comb
    assign result       = fieldOut;
    assign wrEn         = strb.wrEn;
    assign illegalField = strb.illegal;
  end
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk
  import bfx_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              issue,
  input logic [DATA_W-1:0] srcVal,
  input logic [POS_W-1:0]  fieldPos,
  input logic [LEN_W-1:0]  fieldLen,
  input logic              sgnExt,
  input logic [REG_W-1:0]  destIdx,
  input logic [DATA_W-1:0] result,
  input logic              wrEn,
  input logic              illegalField
);
  logic primed;
  always_ff @(posedge clk) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R9: outputs quiet while reset was applied
  assert_reset_quiet_R9: assert property (@(posedge clk)
    (OUT_REG && $past(!rstN) && !rstN) |-> (result == '0 && !wrEn && !illegalField));

  // R8: write only for an issued op to a nonzero register
  assert_no_r0_write_R8: assert property (@(posedge clk) disable iff (!rstN || !OUT_REG)
    (primed && wrEn) |-> ($past(issue) && $past(destIdx) != '0));

  assert_write_taken_R8: assert property (@(posedge clk) disable iff (!rstN || !OUT_REG)
    (primed && $past(issue) && $past(destIdx) != '0) |-> wrEn);

  // R2: zero-extend leaves nothing above a legal field
  assert_unsigned_upper_R2: assert property (@(posedge clk) disable iff (!rstN || !OUT_REG)
    (primed && !$past(sgnExt) && !illegalField && $past(fieldLen) < LEN_W'(DATA_W))
      |-> ((result >> $past(fieldLen)) == '0));

  // R4: one-bit signed field spreads to the whole word
  assert_one_bit_signed_R4: assert property (@(posedge clk) disable iff (!rstN || !OUT_REG)
    (primed && $past(sgnExt) && $past(fieldLen) == LEN_W'(1))
      |-> ($countones(result) == 0 || $countones(result) == DATA_W));

  // R6: whole-word field passes the source through
  assert_full_word_R6: assert property (@(posedge clk) disable iff (!rstN || !OUT_REG)
    (primed && $past(fieldPos) == POS_W'(DATA_W - 1) && $past(fieldLen) == LEN_W'(DATA_W))
      |-> (result == $past(srcVal) && !illegalField));

  // R7: length zero always flagged with an empty result
  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rstN || !OUT_REG)
    (primed && $past(fieldLen) == '0) |-> (illegalField && result == '0));
endmodule

bind bfx_unit bfx_unit_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rstN(rstN), .issue(issue), .srcVal(srcVal), .fieldPos(fieldPos),
  .fieldLen(fieldLen), .sgnExt(sgnExt), .destIdx(destIdx), .result(result),
  .wrEn(wrEn), .illegalField(illegalField)
);

// File: tb/bfx_unit_tb.sv
module bfx_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issue = 1'b0;
  logic [31:0] srcVal = '0;
  logic [4:0]  fieldPos = '0;
  logic [5:0]  fieldLen = '0;
  logic        sgnExt = 1'b0;
  logic [4:0]  destIdx = '0;
  logic [31:0] result;
  logic        wrEn;
  logic        illegalField;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfx_unit u_dut (
    .clk(clk), .rstN(rstN), .issue(issue), .srcVal(srcVal), .fieldPos(fieldPos),
    .fieldLen(fieldLen), .sgnExt(sgnExt), .destIdx(destIdx), .result(result),
    .wrEn(wrEn), .illegalField(illegalField)
  );

  // reference: walk the field in big-endian terms
  function automatic logic [31:0] refExtract(logic [31:0] s, int p, int n, bit sg);
    logic [31:0] r = '0;
    int lo = p - n + 1;
    int cnt;
    if (lo < 0) lo = 0;
    cnt = (n == 0) ? 0 : p - lo + 1;
    for (int k = 0; k < cnt; k++) r[k] = s[31 - (p - k)];
    if (sg && cnt > 0 && s[31 - lo])
      for (int k = cnt; k < 32; k++) r[k] = 1'b1;
    return r;
  endfunction

  function automatic bit refIllegal(int p, int n);
    return (n == 0) || (n > p + 1);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // drive at negedge, sample one negedge later (one register stage)
  task automatic runOp(logic [31:0] s, int p, int n, bit sg, int d, bit iss);
    @(negedge clk);
    srcVal = s; fieldPos = 5'(p); fieldLen = 6'(n); sgnExt = sg;
    destIdx = 5'(d); issue = iss;
    @(negedge clk);
  endtask

  task automatic runAndCheck(string req, logic [31:0] s, int p, int n, bit sg);
    runOp(s, p, n, sg, 3, 1'b1);
    check(req, "result", result, refExtract(s, p, n, sg));
    check(req, "illegal", {31'b0, illegalField}, {31'b0, refIllegal(p, n)});
  endtask

  task automatic testReset();
    check("R9", "reset result", result, 32'h0);
    check("R9", "reset wrEn", {31'b0, wrEn}, 32'h0);
    check("R9", "reset illegal", {31'b0, illegalField}, 32'h0);
  endtask

  task automatic testHalfword();
    runOp(32'h1234_8001, 31, 16, 1'b0, 4, 1'b1);
    check("R5", "low half unsigned", result, 32'h0000_8001);
    runOp(32'h1234_8001, 31, 16, 1'b1, 4, 1'b1);
    check("R5", "low half signed", result, 32'hFFFF_8001);
    runOp(32'hFFFF_7FFE, 31, 16, 1'b1, 4, 1'b1);
    check("R5", "low half positive", result, 32'h0000_7FFE);
  endtask

  task automatic testFullWord();
    runOp(32'hDEAD_BEEF, 31, 32, 1'b0, 1, 1'b1);
    check("R6", "full unsigned", result, 32'hDEAD_BEEF);
    runOp(32'hDEAD_BEEF, 31, 32, 1'b1, 1, 1'b1);
    check("R6", "full signed", result, 32'hDEAD_BEEF);
    check("R6", "full not illegal", {31'b0, illegalField}, 32'h0);
  endtask

  task automatic testOneBit();
    runOp(32'h8000_0000, 0, 1, 1'b1, 2, 1'b1);
    check("R4", "MSB set signed", result, 32'hFFFF_FFFF);
    runOp(32'h7FFF_FFFF, 0, 1, 1'b1, 2, 1'b1);
    check("R4", "MSB clear signed", result, 32'h0);
    runOp(32'h0000_0001, 31, 1, 1'b1, 2, 1'b1);
    check("R4", "LSB set signed", result, 32'hFFFF_FFFF);
    runOp(32'h8000_0000, 0, 1, 1'b0, 2, 1'b1);
    check("R1", "MSB unsigned", result, 32'h1);
  endtask

  task automatic testNumbering();
    // big-endian bits 20..27 = little-endian byte [11:4]
    runOp(32'h0000_0AB0, 27, 8, 1'b0, 5, 1'b1);
    check("R1", "byte straddle", result, 32'h0000_00AB);
    for (int k = 0; k < 40; k++) begin
      logic [31:0] s = 32'h9E37_79B9 * (k + 1) ^ (32'h5bd1_e995 >> (k % 7));
      int p = (k * 7 + 3) % 32;
      int n = (k * 5) % (p + 1) + 1;
      runAndCheck("R1", s, p, n, 1'b0);
      check("R2", "upper zero", result >> n, 32'h0);
    end
  endtask

  task automatic testSigned();
    runOp(32'h0000_0F00, 23, 4, 1'b1, 5, 1'b1);
    check("R3", "nibble negative", result, 32'hFFFF_FFFF);
    runOp(32'h0000_0700, 23, 4, 1'b1, 5, 1'b1);
    check("R3", "nibble positive", result, 32'h0000_0007);
    for (int k = 0; k < 40; k++) begin
      logic [31:0] s = 32'hC2B2_AE35 * (k + 3) + 32'h27d4_eb2f;
      int p = (k * 11 + 5) % 32;
      int n = (k * 3) % (p + 1) + 1;
      runAndCheck("R3", s, p, n, 1'b1);
    end
  endtask

  task automatic testTruncate();
    // pos 3, len 8: only bits 0..3 remain (top nibble)
    runOp(32'hA000_0000, 3, 8, 1'b0, 6, 1'b1);
    check("R7", "trunc unsigned", result, 32'h0000_000A);
    check("R7", "trunc flag", {31'b0, illegalField}, 32'h1);
    runOp(32'hA000_0000, 3, 8, 1'b1, 6, 1'b1);
    check("R7", "trunc signed", result, 32'hFFFF_FFFA);
    runAndCheck("R7", 32'h1357_9BDF, 10, 32, 1'b1);
    runOp(32'hFFFF_FFFF, 15, 0, 1'b1, 6, 1'b1);
    check("R7", "len0 result", result, 32'h0);
    check("R7", "len0 flag", {31'b0, illegalField}, 32'h1);
    runOp(32'hFFFF_FFFF, 15, 16, 1'b0, 6, 1'b1);
    check("R7", "exact fit flag", {31'b0, illegalField}, 32'h0);
  endtask

  task automatic testDestZero();
    runOp(32'h0000_1234, 31, 16, 1'b0, 0, 1'b1);
    check("R8", "r0 no write", {31'b0, wrEn}, 32'h0);
    check("R8", "r0 result still", result, 32'h0000_1234);
    runOp(32'h0000_1234, 31, 16, 1'b0, 31, 1'b1);
    check("R8", "r31 write", {31'b0, wrEn}, 32'h1);
    runOp(32'h0000_1234, 31, 16, 1'b0, 9, 1'b0);
    check("R8", "no issue", {31'b0, wrEn}, 32'h0);
  endtask

  task automatic testLatency();
    runOp(32'h0000_0055, 31, 8, 1'b0, 7, 1'b1);
    check("R9", "first value", result, 32'h55);
    @(negedge clk);
    srcVal = 32'h0000_00AA;
    #1;
    check("R9", "held before edge", result, 32'h55);
    @(negedge clk);
    check("R9", "after edge", result, 32'hAA);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testHalfword();
    testFullWord();
    testOneBit();
    testNumbering();
    testSigned();
    testTruncate();
    testDestZero();
    testLatency();
    finish();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end
endmodule